// File: doc/BRIEF.md
# Period-Match Timer with Pre/Postscaler

An 8-bit up-counter advances on a base tick that fires once every four system clocks, further slowed by a selectable input prescaler. A comparator checks the counter against a programmable period value on every increment; when they are equal the counter restarts from zero and the block emits a single-clock match pulse. That pulse leaves the block unscaled, so it can serve as a time base for a PWM generator or as a shift clock for a serial engine.

The same match pulse also drives a separate 4-bit postscaler. After a selectable number of matches (1 to 16), the postscaler sets a sticky interrupt flag. The flag drives the interrupt request only while an external enable is high. The period and the interrupt rate can therefore be set independently.

Software reaches the block through a small register port. Address 0 is control, 1 is the counter, 2 is the period and 3 is the flag. Writes take effect on the next clock edge. Reads are combinational.

Top module: `period_timer`

## Requirements
- R1: After reset, control reads 0x00, the counter reads 0x00, the period reads 0xFF, the flag reads 0, and irq and match_pulse are low.
- R2: While running, successive match pulses are 4*D*(P+1) clocks apart. P is the period value. D comes from control bits 1:0: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 give 16.
- R3: Each match_pulse lasts exactly one clock, and no postscaler setting changes its rate.
- R4: With control bits 6:3 holding S, the flag sets on the (S+1)-th match pulse that follows a control write. It reads 1 in the cycle after that pulse.
- R5: The flag (address 3, bit 0) stays set until a write to address 3 with bit 0 equal to 0 clears it. If a clear write and a postscaler event fall in the same cycle, the flag ends up set.
- R6: irq is high exactly when the flag is set and irq_en is high.
- R7: While control bit 2 is 0, the counter holds its value and no match pulses appear.
- R8: Control reads back bits 6:0 as written, and bit 7 always reads 0.
- R9: A write to address 1 loads the counter with the written value. A write to address 1 or to address 0 restarts the prescaler and postscaler counts. A write to address 2 changes only the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| match_pulse | output | 1 | Unscaled one-clock period-match pulse |

## Verification
The bench measures the spacing of match pulses under each prescaler code, including the aliased code 2'b11. It uses periods of zero, small and mid-range, so that errors in the base divide, in the prescale decode and in the off-by-one of the period compare each show up as a different interval. Postscaler settings of 1, 5 and 16 are counted in match pulses from a control write to the flag rising, which separates a wrong terminal count from a missing restart. A clear written in the same cycle as a postscaler event, a stopped timer and the interrupt gating each isolate one piece of the flag path.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_CNT  = 2'd1,
      REG_PER  = 2'd2,
      REG_FLAG = 2'd3
   } reg_sel_e;

   localparam int CTRL_ON_BIT   = 2;
   localparam int CTRL_POST_LSB = 3;
   localparam int PRE_CNT_W     = 4;

   function automatic logic [PRE_CNT_W-1:0] pre_last(input logic [1:0] code);
      case (code)
         2'b00:   return 4'd0;
         2'b01:   return 4'd3;
         default: return 4'd15;
      endcase
   endfunction
endpackage

// File: rtl/pt_base_tick.sv
module pt_base_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int QW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad
         $error("pt_base_tick: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         logic [QW-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)                     q <= '0;
            else if (q == QW'(DIV - 1))     q <= '0;
            else                            q <= q + 1'b1;
         end
         assign tick = (q == QW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/pt_prescaler.sv
module pt_prescaler
   import period_timer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       run,
   input  logic       clr,
   input  logic [1:0] sel,
   output logic       inc
);
   logic [PRE_CNT_W-1:0] pc;
   logic [PRE_CNT_W-1:0] last;

   assign last = pre_last(sel);
   assign inc  = tick & run & (pc == last);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)       pc <= '0;
      else if (tick && run)    pc <= (pc == last) ? '0 : pc + 1'b1;
   end

   // R9
   pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc <= pre_last(sel));
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt,
   output logic         match
);
   generate
      if (W < 2) begin : g_bad
         $error("pt_counter: W must be at least 2");
      end
   endgenerate

   logic hit;
   assign hit = inc & (cnt == period);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         match <= 1'b0;
      end else begin
         match <= hit & ~load;
         if (load)      cnt <= load_val;
         else if (hit)  cnt <= '0;
         else if (inc)  cnt <= cnt + 1'b1;
      end
   end

   // R2
   match_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> cnt == '0);
endmodule

// File: rtl/pt_postscaler.sv
module pt_postscaler #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pulse,
   input  logic         clr,
   input  logic [W-1:0] sel,
   output logic         evt
);
   logic [W-1:0] pc;
   assign evt = pulse & (pc == sel);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  pc <= '0;
      else if (pulse)     pc <= evt ? '0 : pc + 1'b1;
   end

   // R4
   post_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc <= sel);
endmodule

// File: rtl/period_timer.sv
module period_timer
   import period_timer_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int POST_W   = 4,
   parameter int BASE_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             irq_en,
   output logic             irq,
   output logic             match_pulse
);
   localparam int CTRL_W = CTRL_POST_LSB + POST_W;

   generate
      if (CTRL_W > CNT_W) begin : g_bad
         $error("period_timer: control fields do not fit the data width");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  period_q;
   logic [CNT_W-1:0]  cnt;
   logic              flag_q;
   logic              tick, inc, post_evt;
   logic              wr_ctrl, wr_cnt, wr_per, wr_flag, restart, run;

   assign wr_ctrl = wr_en & (wr_addr == REG_CTRL);
   assign wr_cnt  = wr_en & (wr_addr == REG_CNT);
   assign wr_per  = wr_en & (wr_addr == REG_PER);
   assign wr_flag = wr_en & (wr_addr == REG_FLAG);
   assign restart = wr_ctrl | wr_cnt;
   assign run     = ctrl_q[CTRL_ON_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '1;
         flag_q   <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q   <= wr_data[CTRL_W-1:0];
         if (wr_per)  period_q <= wr_data;
         if (post_evt)                  flag_q <= 1'b1;
         else if (wr_flag && !wr_data[0]) flag_q <= 1'b0;
      end
   end

   pt_base_tick #(.DIV(BASE_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   pt_prescaler u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .clr(restart),
      .sel(ctrl_q[1:0]), .inc(inc));

   pt_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc), .load(wr_cnt), .load_val(wr_data),
      .period(period_q), .cnt(cnt), .match(match_pulse));

   pt_postscaler #(.W(POST_W)) u_post (
      .clk(clk), .rst_n(rst_n), .pulse(match_pulse), .clr(restart),
      .sel(ctrl_q[CTRL_W-1:CTRL_POST_LSB]), .evt(post_evt));

   assign irq = flag_q & irq_en;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         REG_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
         REG_CNT:  rd_data = cnt;
         REG_PER:  rd_data = period_q;
         default:  rd_data[0] = flag_q;
      endcase
   end

   // R3
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |=> !match_pulse);

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !wr_flag) |=> flag_q);

   // R4
   flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(post_evt));

   // R7
   stopped_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(run));

   // R7
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_cnt) |=> $stable(cnt));
endmodule

// File: tb/period_timer_test.sv
module period_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       irq_en = 1'b0;
   logic       irq;
   logic       match_pulse;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last_cyc = 0;
   bit have_last = 1'b0;
   bit prev_pulse = 1'b0;
   int pulse_total = 0;
   int exp_q[$];

   always #2 clk = ~clk;

   period_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_en(irq_en), .irq(irq), .match_pulse(match_pulse));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops expected intervals, checks pulse width (R3)
   always @(negedge clk) begin
      cyc++;
      if (match_pulse) begin
         pulse_total++;
         if (prev_pulse) check(1'b0, "R3 pulse width", 2, 1);
         if (have_last && exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            check(cyc - last_cyc == e, "R2 match interval", cyc - last_cyc, e);
         end
         have_last = 1'b1;
         last_cyc = cyc;
      end
      prev_pulse = match_pulse;
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   // driver: program a setting and push the expected intervals (R2)
   task automatic run_interval(input logic [1:0] pre, input logic [7:0] per, input int div);
      wr(2'd0, 8'h00);
      exp_q.delete();
      have_last = 1'b0;
      wr(2'd2, per);
      wr(2'd1, 8'h00);
      wr(2'd0, {6'b0, pre} | 8'h04);
      for (int i = 0; i < 3; i++) exp_q.push_back(4 * div * (per + 1));
      for (int t = 0; t < 20000 && exp_q.size() > 0; t++) @(negedge clk);
      check(exp_q.size() == 0, "R2 intervals observed", exp_q.size(), 0);
   endtask

   task automatic post_count(input int k, input string req);
      int n;
      logic [7:0] v;
      wr(2'd0, 8'h00);
      wr(2'd2, 8'd2);
      wr(2'd1, 8'd0);
      wr(2'd3, 8'd0);
      wr(2'd0, 8'((k - 1) << 3) | 8'h04);
      rd_addr = 2'd3;
      n = 0;
      for (int t = 0; t < 5000; t++) begin
         @(negedge clk);
         if (match_pulse) n++;
         if (rd_data[0]) break;
      end
      check(n == k, req, n, k);
      v = rd_data;
      check(v[0] == 1'b1, "R5 flag sticky after set", v[0], 1);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v, v2;
      int p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd0, v);  check(v == 8'h00, "R1 control reset", v, 0);
      rd(2'd1, v);  check(v == 8'h00, "R1 counter reset", v, 0);
      rd(2'd2, v);  check(v == 8'hFF, "R1 period reset", v, 255);
      rd(2'd3, v);  check(v == 8'h00, "R1 flag reset", v, 0);
      check(irq == 1'b0, "R1 irq reset", irq, 0);
      check(match_pulse == 1'b0, "R1 match reset", match_pulse, 0);

      // R8 control readback
      wr(2'd0, 8'hFB);
      rd(2'd0, v); check(v == 8'h7B, "R8 control bit7 zero", v, 8'h7B);
      wr(2'd0, 8'h00);

      // R9 counter load, period untouched
      wr(2'd2, 8'd77);
      wr(2'd1, 8'd42);
      rd(2'd1, v); check(v == 8'd42, "R9 counter load", v, 42);
      rd(2'd2, v); check(v == 8'd77, "R9 period kept", v, 77);

      // R2 intervals over prescale codes and periods
      run_interval(2'b00, 8'd0, 1);
      run_interval(2'b00, 8'd9, 4'd1);
      run_interval(2'b01, 8'd3, 4);
      run_interval(2'b10, 8'd1, 16);
      run_interval(2'b11, 8'd1, 16);

      // R7 stopped timer holds
      wr(2'd0, 8'h00);
      wr(2'd1, 8'd5);
      rd(2'd1, v);
      p0 = pulse_total;
      repeat (100) @(negedge clk);
      rd(2'd1, v2);
      check(v2 == v, "R7 counter held", v2, v);
      check(pulse_total == p0, "R7 no pulses while off", pulse_total - p0, 0);

      // R4 postscaler counts (R9 restart via control write)
      post_count(1,  "R4 postscale 1");
      post_count(5,  "R4 postscale 5");
      post_count(16, "R4 postscale 16");

      // R6 interrupt gating
      irq_en = 1'b0;
      @(negedge clk); check(irq == 1'b0, "R6 irq masked", irq, 0);
      irq_en = 1'b1;
      @(negedge clk); check(irq == 1'b1, "R6 irq enabled", irq, 1);

      // R5 clear by writing 0
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h00);
      rd(2'd3, v); check(v[0] == 1'b0, "R5 flag cleared", v[0], 0);
      check(irq == 1'b0, "R6 irq follows flag", irq, 0);

      // R5 set wins over simultaneous clear (postscale 1)
      wr(2'd2, 8'd2);
      wr(2'd0, 8'h04);
      for (int t = 0; t < 2000; t++) begin
         @(negedge clk);
         if (match_pulse) break;
      end
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00;
      @(negedge clk);
      wr_en = 1'b0;
      rd_addr = 2'd3;
      #1 check(rd_data[0] == 1'b1, "R5 set wins over clear", rd_data[0], 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule